// File: doc/BRIEF.md
# Interrupt Request Capture and Acknowledge Stage

This block is the front end of an eight-input fixed-priority interrupt controller. It turns raw request lines into a request register, using one of two trigger modes. In edge mode an input has to be seen low before a rising level counts as a new request. In level mode a high input is itself the request. A mask removes requests from the priority decision. The request register itself still shows them. The block then drives an interrupt output whenever an unmasked request outranks every level that is already in service.

The processor answers with a two-strobe acknowledge. On the first strobe the stage fixes which level is being served, sets its in-service bit and, in edge mode, disarms that input. If the request has disappeared by then, the stage substitutes the lowest level as a default answer and sets no in-service bit. Software can tell a spurious default from a genuine lowest-level request by the in-service bit. After the second strobe, the chosen level and a default flag are presented for one cycle. A non-specific end-of-interrupt strobe retires the highest-priority level in service.

Top module: `irq_capture`

## Requirements
- R1: After reset the request register and the in-service register both read 0, and `int_req` and `ack_vld` are low.
- R2: With `cfg_level` = 0 (edge mode), a low-to-high change on `irq_in[i]` sets request bit i. An input that stays high after its acknowledge raises no further request, even after the end-of-interrupt.
- R3: With `cfg_level` = 1 (level mode), request bit i follows a high `irq_in[i]` with one cycle of delay and uses no edge detection. An input still high when its end-of-interrupt arrives raises `int_req` again.
- R4: A request whose `mask` bit is 1 stays visible in `irr` but cannot raise `int_req`.
- R5: Index 0 has the highest priority and index 7 the lowest. `int_req` is high exactly when the best unmasked request has a lower index than every set in-service bit, or when no in-service bit is set.
- R6: On the first `ack` strobe while `int_req` is high, the best pending level is chosen and its in-service bit is set. In edge mode the input is also disarmed. One cycle after the second `ack` strobe, `ack_vld` is high for one cycle, with `ack_id` holding the chosen level and `ack_dflt` = 0.
- R7: If `int_req` is low at the first `ack` strobe because the request went away, the answer is `ack_id` = 7 with `ack_dflt` = 1, and the in-service register is left unchanged.
- R8: A genuine level-7 acknowledge reports `ack_id` = 7 with `ack_dflt` = 0 and sets in-service bit 7.
- R9: An `eoi` strobe clears only the lowest-index set bit of the in-service register.
- R10: In edge mode, an input that returns low and then high again after its acknowledge raises a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_level | input | 1 | Trigger mode: 0 edge, 1 level |
| irq_in | input | 8 | Request lines, synchronous to clk |
| mask | input | 8 | 1 blocks the matching request from the priority decision |
| ack | input | 1 | One-cycle acknowledge strobe, issued twice per interrupt |
| eoi | input | 1 | One-cycle non-specific end-of-interrupt strobe |
| int_req | output | 1 | Interrupt request to the processor |
| ack_vld | output | 1 | One-cycle pulse after the second acknowledge strobe |
| ack_id | output | 3 | Level chosen at the first acknowledge |
| ack_dflt | output | 1 | 1 when the answer is the default lowest level |
| irr | output | 8 | Request register |
| isr | output | 8 | In-service register |

## Verification
Several checks run on every cycle: `int_req` never rises without an unmasked request outside service, an acknowledge adds exactly one in-service bit, a default acknowledge leaves the in-service register alone, an end-of-interrupt removes exactly one bit, and a default answer always carries the lowest level. The choice of which level wins, the need for a re-arm in edge mode, the second interrupt in level mode, and a request that vanishes between its rise and the acknowledge depend on sequences of stimulus. Those are shown only by the bench's scenarios, which feed each expected answer to a scoreboard.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_WAIT2 = 1'b1
  } seq_state_e;
endpackage

// File: rtl/irqc_prio_find.sv
// Fixed-priority finder: lowest set index wins.
module irqc_prio_find #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_req_capture.sv
// Per-input request capture with edge arm.
module irqc_req_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_level,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic arm_q, arm_d, arm_en;
    logic req_q, req_d;

    always_comb begin
      arm_en = ~irq_in[g] | ack_clr[g];
      arm_d  = ~irq_in[g];
      req_d  = irq_in[g] & (cfg_level | (arm_q & ~ack_clr[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        arm_q <= 1'b0;
        req_q <= 1'b0;
      end else begin
        if (arm_en) arm_q <= arm_d;
        req_q <= req_d;
      end
    end

    assign irr[g] = req_q;
  end
endmodule

// File: rtl/irqc_ack_seq.sv
// Two-strobe acknowledge sequencer.
module irqc_ack_seq
  import irqc_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack,
  input  logic          int_req,
  input  logic [IW-1:0] pend_idx,
  output logic [N-1:0]  ack_set,
  output logic [IW-1:0] ack_id,
  output logic          ack_dflt,
  output logic          ack_vld,
  output logic          idle
);
  localparam logic [IW-1:0] DFLT_ID = IW'(N - 1);

  seq_state_e    state_q, state_d;
  logic [IW-1:0] id_q, id_d;
  logic          dflt_q, dflt_d, vld_q, vld_d, sel_en;

  always_comb begin
    state_d = state_q;
    id_d    = id_q;
    dflt_d  = dflt_q;
    vld_d   = 1'b0;
    sel_en  = 1'b0;
    ack_set = '0;
    case (state_q)
      SEQ_IDLE: if (ack) begin
        sel_en  = 1'b1;
        state_d = SEQ_WAIT2;
        if (int_req) begin
          id_d              = pend_idx;
          dflt_d            = 1'b0;
          ack_set[pend_idx] = 1'b1;
        end else begin
          id_d   = DFLT_ID;
          dflt_d = 1'b1;
        end
      end
      SEQ_WAIT2: if (ack) begin
        vld_d   = 1'b1;
        state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      id_q    <= '0;
      dflt_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
      if (sel_en) begin
        id_q   <= id_d;
        dflt_q <= dflt_d;
      end
    end
  end

  assign ack_id   = id_q;
  assign ack_dflt = dflt_q;
  assign ack_vld  = vld_q;
  assign idle     = (state_q == SEQ_IDLE);
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_level,
  input  logic [N-1:0]  irq_in,
  input  logic [N-1:0]  mask,
  input  logic          ack,
  input  logic          eoi,
  output logic          int_req,
  output logic          ack_vld,
  output logic [IW-1:0] ack_id,
  output logic          ack_dflt,
  output logic [N-1:0]  irr,
  output logic [N-1:0]  isr
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [N-1:0]  ack_set, eoi_clr, pend, isr_q, isr_d;
  logic          p_found, s_found, seq_idle, isr_en;
  logic [IW-1:0] p_idx, s_idx;

  irqc_req_capture #(.N(N)) u_cap (
    .clk(clk), .rst_n(rst_sync_n), .cfg_level(cfg_level),
    .irq_in(irq_in), .ack_clr(ack_set), .irr(irr)
  );

  assign pend = irr & ~mask;

  irqc_prio_find #(.N(N), .IW(IW)) u_pend_find (
    .vec(pend), .found(p_found), .idx(p_idx)
  );
  irqc_prio_find #(.N(N), .IW(IW)) u_isr_find (
    .vec(isr_q), .found(s_found), .idx(s_idx)
  );

  assign int_req = p_found & (~s_found | (p_idx < s_idx));

  irqc_ack_seq #(.N(N), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .ack(ack), .int_req(int_req),
    .pend_idx(p_idx), .ack_set(ack_set), .ack_id(ack_id),
    .ack_dflt(ack_dflt), .ack_vld(ack_vld), .idle(seq_idle)
  );

  always_comb begin
    eoi_clr = '0;
    if (eoi && s_found) eoi_clr[s_idx] = 1'b1;
    isr_d  = (isr_q & ~eoi_clr) | ack_set;
    isr_en = (|eoi_clr) | (|ack_set);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) isr_q <= '0;
    else if (isr_en) isr_q <= isr_d;
  end

  assign isr = isr_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          ack,
  input logic          eoi,
  input logic          int_req,
  input logic          seq_idle,
  input logic          ack_vld,
  input logic          ack_dflt,
  input logic [IW-1:0] ack_id,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  irr,
  input logic [N-1:0]  isr
);
  // R4 / R5: an interrupt needs an unmasked request that is not itself in service
  a_r4_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int_req |-> ((irr & ~mask & ~isr) != '0));

  // R6: a real first acknowledge adds exactly one in-service bit
  a_r6_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq_idle && ack && int_req && !eoi) |=> ($countones(isr) == $past($countones(isr)) + 1));

  // R7: a default acknowledge leaves the in-service register as it was
  a_r7_default_keeps_isr: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq_idle && ack && !int_req && !eoi) |=> (isr == $past(isr)));

  // R7: a default answer always carries the lowest level
  a_r7_default_id: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_vld && ack_dflt) |-> (ack_id == IW'(N - 1)));

  // R9: end-of-interrupt without a concurrent selection retires exactly one bit
  a_r9_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eoi && !(seq_idle && ack) && (isr != '0)) |=> ($countones(isr) == $past($countones(isr)) - 1));

  // R6: the result pulse lasts a single cycle
  a_r6_vld_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack_vld |=> !ack_vld);
endmodule

bind irq_capture irqc_checker #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .ack(ack), .eoi(eoi),
  .int_req(int_req), .seq_idle(seq_idle), .ack_vld(ack_vld),
  .ack_dflt(ack_dflt), .ack_id(ack_id), .mask(mask), .irr(irr), .isr(isr)
);

// File: tb/irq_capture_test.sv
`timescale 1ns/1ps
module irq_capture_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_level = 1'b0;
  logic [7:0] irq_in = '0;
  logic [7:0] mask = '0;
  logic       ack = 1'b0;
  logic       eoi = 1'b0;
  logic       int_req, ack_vld, ack_dflt;
  logic [2:0] ack_id;
  logic [7:0] irr, isr;

  int nchecks = 0;
  int nfail   = 0;
  bit done    = 1'b0;
  logic [3:0] exp_q[$];

  always #2.5 clk = ~clk;

  irq_capture uut (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .irq_in(irq_in),
    .mask(mask), .ack(ack), .eoi(eoi), .int_req(int_req), .ack_vld(ack_vld),
    .ack_id(ack_id), .ack_dflt(ack_dflt), .irr(irr), .isr(isr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // driver: pushes the expected answer, then issues both strobes
  task automatic ack_seq(input logic [2:0] id, input logic dflt);
    exp_q.push_back({dflt, id});
    ack = 1'b1; tick();
    ack = 1'b0; tick();
    ack = 1'b1; tick();
    ack = 1'b0; tick();
  endtask

  task automatic do_eoi();
    eoi = 1'b1; tick();
    eoi = 1'b0;
  endtask

  // monitor: compares each result pulse with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && ack_vld) begin
      if (exp_q.size() == 0) begin
        chk("R6 unexpected ack_vld", 32'd1, 32'd0);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk("R6/R7/R8 ack_id", {29'd0, ack_id}, {29'd0, e[2:0]});
        chk("R6/R7/R8 ack_dflt", {31'd0, ack_dflt}, {31'd0, e[3]});
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      nchecks++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1: reset state
    chk("R1 irr", irr, 0);
    chk("R1 isr", isr, 0);
    chk("R1 int_req", int_req, 0);
    chk("R1 ack_vld", ack_vld, 0);

    // R2: edge mode rising edge
    irq_in = 8'h08; tick();
    chk("R2 irr edge", irr, 8'h08);
    chk("R2 int_req", int_req, 1);
    ack_seq(3'd3, 1'b0);
    chk("R6 isr bit3", isr, 8'h08);
    chk("R2 irr cleared while held", irr, 8'h00);
    do_eoi();
    chk("R9 isr after eoi", isr, 8'h00);
    tick();
    chk("R2 no repeat while held", int_req, 0);
    // R10: re-arm
    irq_in = 8'h00; tick();
    irq_in = 8'h08; tick();
    chk("R10 rearm irr", irr, 8'h08);
    chk("R10 rearm int_req", int_req, 1);
    ack_seq(3'd3, 1'b0);
    do_eoi();
    irq_in = 8'h00; tick();

    // R7: request vanishes before acknowledge
    irq_in = 8'h20; tick();
    chk("R7 pending", int_req, 1);
    irq_in = 8'h00; tick();
    chk("R7 irr gone", irr, 8'h00);
    ack_seq(3'd7, 1'b1);
    chk("R7 no isr bit", isr, 8'h00);

    // R8: genuine level 7
    irq_in = 8'h80; tick();
    ack_seq(3'd7, 1'b0);
    chk("R8 isr bit7", isr, 8'h80);
    do_eoi();
    chk("R9 isr bit7 cleared", isr, 8'h00);
    irq_in = 8'h00; tick();

    // R5: priority and nesting
    irq_in = 8'h24; tick();
    ack_seq(3'd2, 1'b0);
    chk("R5 isr bit2", isr, 8'h04);
    chk("R5 lower level blocked", int_req, 0);
    irq_in = 8'h26; tick();
    chk("R5 higher level nests", int_req, 1);
    ack_seq(3'd1, 1'b0);
    chk("R5 isr nested", isr, 8'h06);
    do_eoi();
    chk("R9 clears highest first", isr, 8'h04);
    do_eoi();
    chk("R9 second eoi", isr, 8'h00);
    chk("R5 waiting level now wins", int_req, 1);
    ack_seq(3'd5, 1'b0);
    do_eoi();
    irq_in = 8'h00; tick();

    // R4: mask
    mask = 8'h01; irq_in = 8'h01; tick();
    chk("R4 irr visible", irr, 8'h01);
    chk("R4 masked no int", int_req, 0);
    mask = 8'h00; #1;
    chk("R4 unmasked int", int_req, 1);
    ack_seq(3'd0, 1'b0);
    do_eoi();
    irq_in = 8'h00; tick();

    // R3: level mode
    cfg_level = 1'b1; tick();
    irq_in = 8'h10; tick();
    chk("R3 level irr", irr, 8'h10);
    chk("R3 level int", int_req, 1);
    ack_seq(3'd4, 1'b0);
    chk("R3 isr bit4", isr, 8'h10);
    chk("R3 irr still high", irr, 8'h10);
    chk("R3 in service no int", int_req, 0);
    do_eoi();
    chk("R3 second interrupt", int_req, 1);
    ack_seq(3'd4, 1'b0);
    irq_in = 8'h00; tick();
    do_eoi();
    chk("R3 request removed", irr, 8'h00);
    chk("R3 no int after removal", int_req, 0);

    tick();
    chk("R6 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule